// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This controller sits on the host side of a parallel, byte-wide flash bus and turns high-level requests into the pin-level traffic such a part expects. A requester presents one of four operations on a valid/ready handshake: program one byte, erase the whole array, permanently lock the low boot region, or read the identification bytes. The sequencer expands the request into the unlock write sequence the flash part requires. It drives address, data and the active-low chip-enable, write-enable and output-enable pins. Setup, strobe and hold lengths are set by parameters. It then watches the device until the operation has finished.

Completion detection depends on the operation. After a byte program, the target byte is read back until its top bit matches the top bit that was written. After an erase or a lock, address zero is read until bit 6 holds the same value on two reads in a row. Polling starts immediately after the last command write and is bounded by a read limit, so a device that never settles still produces a response, with the timeout flag set. An identification request enters the ID mode and reads three bytes. It then leaves the mode with a single write and returns the bytes packed together.

Top module: `flash_cmd_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle; a request is taken on a cycle with `req_valid` and `req_ready` both high, and each taken request yields exactly one single-cycle `rsp_valid` pulse, after which `req_ready` is high again. Operation codes on `req_op`: 0 program, 1 chip erase, 2 boot lock, 3 identify.
- R2: A program request performs exactly four writes, in order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request address.
- R3: An erase request performs six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h; a lock request performs the same six writes except that the last one carries 40h.
- R4: After a program, every poll read targets the request address, and the first poll read follows the last write with no added wait. The request completes without timeout on the first read whose bit 7 equals bit 7 of the written data, and `rsp_rdata[7:0]` returns that read value.
- R5: After an erase or lock, every poll read targets address 0, and the request completes without timeout on the first read whose bit 6 equals bit 6 of the read immediately before it.
- R6: When POLL_LIMIT poll reads pass without meeting the completion condition, polling stops after exactly POLL_LIMIT reads and the response carries `rsp_timeout` = 1.
- R7: An identify request writes AAh@5555h, 55h@2AAAh and 90h@5555h, then reads addresses 0, 1 and 2, and then writes F0h@5555h. The response carries `rsp_timeout` = 0 and `rsp_rdata` = {byte at 2, byte at 1, byte at 0}.
- R8: In every write, CE# and WE# fall together and stay low for exactly PULSE cycles, and OE# stays high throughout. Address and data are driven, with `f_doe` = 1, and stay stable across both the falling and the rising strobe edges.
- R9: In every read, CE# and OE# are low for RD_CYC cycles while WE# is high and `f_doe` is 0; a read strobe and a write strobe never overlap.
- R10: During and straight after reset, CE#, WE# and OE# are high, `f_doe` is 0, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | Operation code (0 program, 1 erase, 2 lock, 3 identify) |
| req_addr | input | AW | Target byte address for program |
| req_data | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Polling limit reached without completion |
| rsp_rdata | output | 24 | Identify bytes, or the final poll read in bits 7:0 |
| f_addr | output | AW | Flash address bus |
| f_dout | output | 8 | Data driven toward the flash |
| f_doe | output | 1 | Data bus drive enable |
| f_din | input | 8 | Data returned by the flash |
| f_ce_n | output | 1 | Chip enable, active low |
| f_we_n | output | 1 | Write enable, active low |
| f_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest situation to reach is the edge between completion and timeout. The device must keep bit 7 inverted, or bit 6 toggling, for a chosen number of reads, and the number of poll reads and the timeout flag must then match that count. The bench uses a behavioural flash model whose busy duration is set per request. Directed cases hold the part busy past the limit for both polling styles. Random requests pick short busy lengths and revisit a few addresses, so a later program can find a 0 in bit 7 that it cannot turn into 1. That gives a timeout even though the device is never busy.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW         = 19,
  parameter int SETUP      = 2,
  parameter int PULSE      = 3,
  parameter int HOLD       = 2,
  parameter int RD_CYC     = 3,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          rsp_valid,
  output logic          rsp_timeout,
  output logic [23:0]   rsp_rdata,
  output logic [AW-1:0] f_addr,
  output logic [7:0]    f_dout,
  output logic          f_doe,
  input  logic [7:0]    f_din,
  output logic          f_ce_n,
  output logic          f_we_n,
  output logic          f_oe_n
);

  localparam int T1   = (SETUP > PULSE) ? SETUP : PULSE;
  localparam int T2   = (HOLD > RD_CYC) ? HOLD : RD_CYC;
  localparam int TMAX = (T1 > T2) ? T1 : T2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POLL_LIMIT + 1);

  localparam logic [1:0] OP_PROG = 2'd0;
  localparam logic [1:0] OP_LOCK = 2'd2;
  localparam logic [1:0] OP_ID   = 2'd3;

  localparam logic [AW-1:0] A_HI = AW'('h5555);
  localparam logic [AW-1:0] A_LO = AW'('h2AAA);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_RSP} st_t;

  st_t           st;
  logic [1:0]    ph;
  logic [CW-1:0] cnt;
  logic [2:0]    step;
  logic [1:0]    op;
  logic [AW-1:0] tgt_a;
  logic [7:0]    tgt_d;
  logic [PW-1:0] poll_cnt;
  logic          prev6, have_prev;
  logic [7:0]    rd_val;
  logic [23:0]   rbuf;
  logic          tmo;

  logic [CW-1:0] ph_len;
  logic [AW-1:0] cur_a;
  logic [7:0]    cur_d;
  logic [2:0]    nwr;
  logic          ph_end, poll_ok, last_poll;

  always_comb begin
    case (ph)
      2'd0:    ph_len = CW'(SETUP);
      2'd1:    ph_len = (st == S_WR) ? CW'(PULSE) : CW'(RD_CYC);
      default: ph_len = (st == S_WR) ? CW'(HOLD) : CW'(1);
    endcase
  end

  always_comb begin
    cur_a = A_HI;
    cur_d = 8'hAA;
    if (st == S_RD) begin
      cur_d = 8'h00;
      if (op == OP_ID)        cur_a = AW'(step - 3'd3);
      else if (op == OP_PROG) cur_a = tgt_a;
      else                    cur_a = '0;
    end else begin
      case (step)
        3'd0: begin cur_a = A_HI; cur_d = 8'hAA; end
        3'd1: begin cur_a = A_LO; cur_d = 8'h55; end
        3'd2: begin
          cur_a = A_HI;
          cur_d = (op == OP_PROG) ? 8'hA0 : (op == OP_ID) ? 8'h90 : 8'h80;
        end
        3'd3: begin
          cur_a = (op == OP_PROG) ? tgt_a : A_HI;
          cur_d = (op == OP_PROG) ? tgt_d : 8'hAA;
        end
        3'd4: begin cur_a = A_LO; cur_d = 8'h55; end
        3'd5: begin cur_a = A_HI; cur_d = (op == OP_LOCK) ? 8'h40 : 8'h10; end
        default: begin cur_a = A_HI; cur_d = 8'hF0; end
      endcase
    end
  end

  assign nwr       = (op == OP_PROG) ? 3'd4 : (op == OP_ID) ? 3'd3 : 3'd6;
  assign ph_end    = (cnt == ph_len - CW'(1));
  assign poll_ok   = (op == OP_PROG) ? (rd_val[7] == tgt_d[7])
                                     : (have_prev && (prev6 == rd_val[6]));
  assign last_poll = (poll_cnt == PW'(POLL_LIMIT - 1));

  assign req_ready   = (st == S_IDLE);
  assign rsp_valid   = (st == S_RSP);
  assign rsp_timeout = tmo;
  assign rsp_rdata   = rbuf;
  assign f_addr      = cur_a;
  assign f_dout      = (st == S_WR) ? cur_d : 8'h00;
  assign f_doe       = (st == S_WR);
  assign f_ce_n      = !(((st == S_WR) || (st == S_RD)) && (ph == 2'd1));
  assign f_we_n      = !((st == S_WR) && (ph == 2'd1));
  assign f_oe_n      = !((st == S_RD) && (ph == 2'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= 2'd0;
      cnt       <= '0;
      step      <= 3'd0;
      op        <= 2'd0;
      tgt_a     <= '0;
      tgt_d     <= 8'h00;
      poll_cnt  <= '0;
      prev6     <= 1'b0;
      have_prev <= 1'b0;
      rd_val    <= 8'h00;
      rbuf      <= 24'h0;
      tmo       <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op        <= req_op;
          tgt_a     <= req_addr;
          tgt_d     <= req_data;
          step      <= 3'd0;
          ph        <= 2'd0;
          cnt       <= '0;
          poll_cnt  <= '0;
          have_prev <= 1'b0;
          rbuf      <= 24'h0;
          tmo       <= 1'b0;
          st        <= S_WR;
        end
        S_RSP: st <= S_IDLE;
        default: begin
          if ((st == S_RD) && (ph == 2'd1) && ph_end) rd_val <= f_din;
          if (!ph_end) cnt <= cnt + CW'(1);
          else begin
            cnt <= '0;
            if (ph != 2'd2) ph <= ph + 2'd1;
            else begin
              ph <= 2'd0;
              if (st == S_WR) begin
                if (step == 3'd6) st <= S_RSP;
                else if (step + 3'd1 < nwr) step <= step + 3'd1;
                else begin
                  step <= (op == OP_ID) ? 3'd3 : nwr;
                  st   <= S_RD;
                end
              end else if (op == OP_ID) begin
                case (step)
                  3'd3:    rbuf[7:0]   <= rd_val;
                  3'd4:    rbuf[15:8]  <= rd_val;
                  default: rbuf[23:16] <= rd_val;
                endcase
                if (step == 3'd5) st <= S_WR;
                step <= step + 3'd1;
              end else begin
                rbuf      <= {16'h0, rd_val};
                prev6     <= rd_val[6];
                have_prev <= 1'b1;
                if (poll_ok) st <= S_RSP;
                else if (last_poll) begin
                  tmo <= 1'b1;
                  st  <= S_RSP;
                end else poll_cnt <= poll_cnt + PW'(1);
              end
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] f_addr,
  input logic [7:0]    f_dout,
  input logic          f_doe,
  input logic          f_ce_n,
  input logic          f_we_n,
  input logic          f_oe_n
);

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r1_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r1_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

  a_r8_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !f_we_n |-> (f_oe_n && !f_ce_n && f_doe));

  a_r8_setup_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_we_n) |-> ($stable(f_addr) && $stable(f_dout) && $past(f_doe)));

  a_r8_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_we_n) |-> (f_doe && $stable(f_addr) && $stable(f_dout)));

  a_r9_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !f_oe_n |-> (f_we_n && !f_doe && !f_ce_n));

  a_r9_read_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_oe_n && $past(!f_oe_n)) |-> $stable(f_addr));

  a_r10_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (f_ce_n && f_we_n && f_oe_n && !f_doe));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .f_addr(f_addr), .f_dout(f_dout), .f_doe(f_doe),
  .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int AW = 19, SETUP = 2, PULSE = 3, HOLD = 2, RD_CYC = 3, PL = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = 8'h00;
  logic rsp_valid, rsp_timeout;
  logic [23:0] rsp_rdata;
  logic [AW-1:0] f_addr;
  logic [7:0] f_dout, f_din = 8'hFF;
  logic f_doe, f_ce_n, f_we_n, f_oe_n;

  always #4 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .SETUP(SETUP), .PULSE(PULSE), .HOLD(HOLD),
                  .RD_CYC(RD_CYC), .POLL_LIMIT(PL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
    .f_addr(f_addr), .f_dout(f_dout), .f_doe(f_doe), .f_din(f_din),
    .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n));

  int checks = 0, errors = 0;

  // behavioural flash part
  logic [7:0] mem [int];
  logic [26:0] wr_log [$];
  int rd_addr_log [$];
  int rd_n, pulse_err, ovl_err, rsp_seen, busy_cfg, m_busy, we_cnt, cpos;
  bit we_prev, rd_prev, idmode, locked, m_prog, tog;
  logic [7:0] m_last;

  function automatic logic [7:0] mval(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  task automatic m_write(int a, logic [7:0] d);
    wr_log.push_back({a[18:0], d});
    if (idmode && d == 8'hF0) begin idmode = 0; cpos = 0; return; end
    case (cpos)
      0: cpos = (a == 'h5555 && d == 8'hAA) ? 1 : 0;
      1: cpos = (a == 'h2AAA && d == 8'h55) ? 2 : 0;
      2: begin
        cpos = 0;
        if (a == 'h5555 && d == 8'hA0) cpos = 10;
        if (a == 'h5555 && d == 8'h80) cpos = 3;
        if (a == 'h5555 && d == 8'h90) idmode = 1;
      end
      3: cpos = (a == 'h5555 && d == 8'hAA) ? 4 : 0;
      4: cpos = (a == 'h2AAA && d == 8'h55) ? 5 : 0;
      5: begin
        cpos = 0;
        if (a == 'h5555 && (d == 8'h10 || d == 8'h40)) begin
          if (d == 8'h40) locked = 1;
          else if (locked) begin
            foreach (mem[k]) if (k >= 'h4000) mem[k] = 8'hFF;
          end else mem.delete();
          m_prog = 0; m_busy = busy_cfg;
        end
      end
      10: begin
        cpos = 0;
        if (!(locked && a < 'h4000)) begin
          mem[a] = mval(a) & d;
          m_prog = 1; m_last = d; m_busy = busy_cfg;
        end
      end
      default: cpos = 0;
    endcase
  endtask

  task automatic m_read(int a);
    rd_n++;
    rd_addr_log.push_back(a);
    if (idmode) f_din = (a == 0) ? 8'h1F : (a == 1) ? 8'h13 : (a == 2) ? {7'd0, locked} : 8'hFF;
    else if (m_busy > 0) begin
      m_busy--; tog = ~tog;
      f_din = m_prog ? {~m_last[7], tog, 6'd0} : {1'b0, tog, 6'd0};
    end else f_din = mval(a);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!f_ce_n && !f_we_n) we_cnt++;
      else if (we_prev) begin
        if (we_cnt != PULSE) pulse_err++;
        we_cnt = 0;
        m_write(int'(f_addr), f_dout);
      end
      we_prev = !f_ce_n && !f_we_n;
      if (!f_oe_n) begin
        if (f_doe || !f_we_n || f_ce_n) ovl_err++;
        if (!rd_prev) m_read(int'(f_addr));
      end
      rd_prev = !f_oe_n;
      if (rsp_valid) rsp_seen++;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] ew(int a, logic [7:0] d);
    return {a[18:0], d};
  endfunction

  task automatic do_req(logic [1:0] op, int a, logic [7:0] d, int busy);
    logic [26:0] exp_w [$];
    logic [7:0] old, newv;
    bit blocked, e_tmo;
    int e_reads, busy_eff;
    logic got_tmo;
    logic [23:0] got_rd;
    old = mval(a);
    blocked = locked && (a < 'h4000);
    wr_log.delete(); rd_addr_log.delete();
    rd_n = 0; pulse_err = 0; ovl_err = 0; rsp_seen = 0; busy_cfg = busy; m_busy = 0;
    exp_w.push_back(ew('h5555, 8'hAA));
    exp_w.push_back(ew('h2AAA, 8'h55));
    case (op)
      2'd0: begin exp_w.push_back(ew('h5555, 8'hA0)); exp_w.push_back(ew(a, d)); end
      2'd3: begin exp_w.push_back(ew('h5555, 8'h90)); exp_w.push_back(ew('h5555, 8'hF0)); end
      default: begin
        exp_w.push_back(ew('h5555, 8'h80)); exp_w.push_back(ew('h5555, 8'hAA));
        exp_w.push_back(ew('h2AAA, 8'h55));
        exp_w.push_back(ew('h5555, (op == 2'd2) ? 8'h40 : 8'h10));
      end
    endcase
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
    req_valid = 1; req_op = op; req_addr = a[18:0]; req_data = d;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    got_tmo = rsp_timeout; got_rd = rsp_rdata;
    repeat (3) @(negedge clk);
    chk(rsp_seen == 1, "R1 one response pulse", rsp_seen, 1);
    chk(pulse_err == 0, "R8 strobe width", pulse_err, 0);
    chk(ovl_err == 0, "R9 read strobe clean", ovl_err, 0);
    chk(wr_log.size() == exp_w.size(), op == 0 ? "R2 write count" : op == 3 ? "R7 write count" : "R3 write count",
        wr_log.size(), exp_w.size());
    foreach (exp_w[i]) if (i < wr_log.size())
      chk(wr_log[i] == exp_w[i], op == 0 ? "R2 write" : op == 3 ? "R7 write" : "R3 write", wr_log[i], exp_w[i]);
    if (op == 2'd0) begin
      newv = blocked ? old : (old & d);
      busy_eff = blocked ? 0 : busy;
      e_tmo = !(newv[7] == d[7] && busy_eff + 1 <= PL);
      e_reads = e_tmo ? PL : busy_eff + 1;
      chk(got_tmo == e_tmo, e_tmo ? "R6 program timeout" : "R4 program done", got_tmo, e_tmo);
      chk(rd_n == e_reads, e_tmo ? "R6 poll count" : "R4 poll count", rd_n, e_reads);
      if (!e_tmo) chk(got_rd[7:0] == newv, "R4 read data", got_rd[7:0], newv);
      foreach (rd_addr_log[i]) chk(rd_addr_log[i] == a, "R4 poll address", rd_addr_log[i], a);
    end else if (op == 2'd3) begin
      chk(got_tmo == 1'b0, "R7 no timeout", got_tmo, 0);
      chk(got_rd == {7'd0, locked, 8'h13, 8'h1F}, "R7 id bytes", got_rd, {7'd0, locked, 8'h13, 8'h1F});
      chk(rd_addr_log.size() == 3, "R7 read count", rd_addr_log.size(), 3);
      foreach (rd_addr_log[i]) chk(rd_addr_log[i] == i, "R7 read address", rd_addr_log[i], i);
    end else begin
      e_tmo = (busy + 2 > PL);
      chk(got_tmo == e_tmo, e_tmo ? "R6 erase timeout" : "R5 erase done", got_tmo, e_tmo);
      if (e_tmo) chk(rd_n == PL, "R6 poll count", rd_n, PL);
      else chk(rd_n >= ((busy + 1 > 2) ? busy + 1 : 2) && rd_n <= busy + 2, "R5 poll count", rd_n, busy + 2);
      foreach (rd_addr_log[i]) chk(rd_addr_log[i] == 0, "R5 poll address", rd_addr_log[i], 0);
    end
    m_busy = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    cpos = 0; idmode = 0; locked = 0; tog = 0; m_prog = 0; m_last = 8'h00;
    we_cnt = 0; we_prev = 0; rd_prev = 0;
    repeat (3) @(negedge clk);
    chk(f_ce_n && f_we_n && f_oe_n && !f_doe && !rsp_valid && req_ready,
        "R10 reset state", {f_ce_n, f_we_n, f_oe_n, f_doe, rsp_valid, req_ready}, 6'b111001);
    rst_n = 1;
    @(negedge clk);
    chk(f_ce_n && f_we_n && f_oe_n && !f_doe && req_ready, "R10 after reset",
        {f_ce_n, f_we_n, f_oe_n, f_doe, req_ready}, 5'b11101);
    do_req(2'd1, 0, 8'h00, 3);
    do_req(2'd1, 0, 8'h00, 0);
    do_req(2'd0, 'h10, 8'hA5, 4);
    do_req(2'd0, 'h10, 8'h5A, 0);
    do_req(2'd0, 'h20, 8'h00, 2);
    do_req(2'd0, 'h20, 8'h80, 0);
    do_req(2'd0, 'h30, 8'h11, 100);
    do_req(2'd3, 0, 8'h00, 0);
    do_req(2'd1, 0, 8'h00, 1000);
    do_req(2'd2, 0, 8'h00, 2);
    do_req(2'd3, 0, 8'h00, 0);
    do_req(2'd0, 'h100, 8'h00, 3);
    do_req(2'd0, 'h5000, 8'h7F, 3);
    for (int i = 0; i < 40; i++) begin
      int r, a, b;
      r = $urandom % 8;
      a = (($urandom % 2) ? 'h100 : 'h5000) + ($urandom % 4);
      b = ($urandom % 10 == 0) ? 60 : $urandom % 9;
      if (r < 5) do_req(2'd0, a, 8'($urandom), b);
      else if (r == 6) do_req(2'd3, 0, 8'h00, 0);
      else do_req(2'd1, 0, 8'h00, b);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule